// File: doc/BRIEF.md
# Operand Hazard Resolver for a Five-Stage Integer Pipeline

This block sits beside the decode stage of a five-stage, 32-bit integer pipeline. It looks at the source register fields of the instruction being decoded. It compares them against the destination registers of the two older instructions that are still in flight, in the execute stage and in the memory stage. When a dependency exists, the block does one of two things. It can steer a newer value from a later stage onto the decode operand. Or it can raise a stall, which holds fetch and decode and pushes an empty slot into execute on the following cycle.

The field that usually names the second source is a real source only for register-register instructions and for stores. For every other immediate-form instruction that field names the destination. The block therefore classifies the opcode before it compares that field. Register 0 is never treated as a producer. A two-bit policy input selects the handling at run time:
- no handling at all,
- stall on every dependency,
- forward where possible and stall only when forwarding cannot help.

Top module: `hazard_unit_top`

## Requirements
- R1: A later stage creates a dependency only when its register-write flag is high, its destination index is nonzero, and that index equals a compared source field of the decode instruction.
- R2: The first source field, instruction bits [25:21], is compared for every opcode (opcode is bits [31:26]).
- R3: The second source field, bits [20:16], is compared only when the opcode is 0 (register-register) or one of the store opcodes 40, 41, 42, 43, 46. It is never compared for any other opcode, including opcodes with no defined meaning.
- R4: With policy 0 (off), stall is low and both select outputs are 0, whatever the pipeline contents.
- R5: With policy 1 (stall-only), any dependency on either stage raises stall and both selects stay 0.
- R6: With policy 2 (forwarding), a dependency on the execute stage while its load flag is high raises stall.
- R7: With policy 2, a dependency on a non-load execute stage sets that operand's select to 1. The operand output then carries the execute result, and stall stays low.
- R8: With policy 2, a dependency on the memory stage alone sets that operand's select to 2. The operand output then carries the memory-stage result.
- R9: When both stages match the same operand, the execute stage wins (select 1).
- R10: bubble_ex is high in the cycle after a cycle in which stall was high, and low otherwise. A synchronous active-high reset clears it.
- R11: While stall is high, both selects are 0 and the operand outputs carry the register-file values.
- R12: Policy 3 behaves exactly like policy 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | 0 off, 1 stall-only, 2 forwarding, 3 as 1 |
| id_instr | input | 32 | Instruction word in decode |
| rf_rs_val | input | 32 | Register-file value of first source |
| rf_rt_val | input | 32 | Register-file value of second source |
| ex_regwrite | input | 1 | Execute-stage instruction writes a register |
| ex_memread | input | 1 | Execute-stage instruction is a load |
| ex_dest | input | 5 | Execute-stage destination index |
| ex_result | input | 32 | Execute-stage ALU result |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_dest | input | 5 | Memory-stage destination index |
| mem_result | input | 32 | Memory-stage load data or ALU result |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble_ex | output | 1 | Empty slot enters execute this cycle |
| fwd_rs_sel | output | 2 | First-operand source: 0 file, 1 execute, 2 memory |
| fwd_rt_sel | output | 2 | Second-operand source: 0 file, 1 execute, 2 memory |
| opnd_rs | output | 32 | Resolved first operand |
| opnd_rt | output | 32 | Resolved second operand |

## Verification
Every cycle, the assertions check these properties:
- the off policy stays silent;
- a producer with destination 0 or no write flag never provokes action;
- a stall zeroes the selects;
- stall-only mode never forwards;
- the operand outputs agree with their selects;
- bubble_ex trails stall by exactly one cycle.

Which opcodes count the second field as a source, and the execute-over-memory priority, depend on specific instruction words and stage contents. Only the bench's scenarios can show these. The same holds for the load-use stall against forwarding from a load in the memory stage.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int OPW  = 6;

  typedef enum logic [1:0] {
    POL_OFF   = 2'd0,
    POL_STALL = 2'd1,
    POL_FWD   = 2'd2,
    POL_RSV   = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EX  = 2'd1,
    SEL_MEM = 2'd2
  } fwd_sel_e;

  localparam logic [OPW-1:0] OPC_REGREG = '0;
  localparam int NSTORE = 5;
  localparam logic [OPW-1:0] STORE_OPS [NSTORE] = '{6'd40, 6'd41, 6'd42, 6'd43, 6'd46};
endpackage

// File: rtl/hzd_classify.sv
module hzd_classify
  import hzd_pkg::*;
#(
  parameter int OP_W = OPW
) (
  input  logic [OP_W-1:0] opcode,
  output logic            is_regreg,
  output logic            is_store,
  output logic            rt_is_src
);
  logic [NSTORE-1:0] hit;

  for (genvar i = 0; i < NSTORE; i++) begin : g_st
    assign hit[i] = (opcode == STORE_OPS[i]);
  end

  assign is_regreg = (opcode == OPC_REGREG);
  assign is_store  = |hit;
  assign rt_is_src = is_regreg | is_store;
endmodule

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int R_W = 5
) (
  input  logic           regwrite,
  input  logic [R_W-1:0] dest,
  input  logic [R_W-1:0] src_rs,
  input  logic [R_W-1:0] src_rt,
  input  logic           rt_en,
  output logic           m_rs,
  output logic           m_rt
);
  logic live;
  assign live = regwrite && (dest != '0);
  assign m_rs = live && (dest == src_rs);
  assign m_rt = live && rt_en && (dest == src_rt);
endmodule

// File: rtl/hzd_policy.sv
module hzd_policy
  import hzd_pkg::*;
#(
  parameter int NSTG = 2
) (
  input  logic [1:0]      policy,
  input  logic            ex_memread,
  input  logic [NSTG-1:0] m_rs,
  input  logic [NSTG-1:0] m_rt,
  output logic            stall,
  output logic [1:0]      sel_rs,
  output logic [1:0]      sel_rt
);
  localparam int EX  = 0;
  localparam int MEM = 1;

  logic any_dep, ex_dep;
  assign any_dep = (|m_rs) | (|m_rt);
  assign ex_dep  = m_rs[EX] | m_rt[EX];

  function automatic logic [1:0] pick(input logic at_ex, input logic at_mem);
    if (at_ex)       return SEL_EX;
    else if (at_mem) return SEL_MEM;
    else             return SEL_RF;
  endfunction

  always_comb begin
    stall  = 1'b0;
    sel_rs = SEL_RF;
    sel_rt = SEL_RF;
    unique case (policy_e'(policy))
      POL_OFF: ;
      POL_STALL, POL_RSV: stall = any_dep;
      POL_FWD: begin
        stall = ex_dep && ex_memread;
        if (!stall) begin
          sel_rs = pick(m_rs[EX], m_rs[MEM]);
          sel_rt = pick(m_rt[EX], m_rt[MEM]);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hazard_unit_top.sv
module hazard_unit_top
  import hzd_pkg::*;
#(
  parameter int DW   = XLEN,
  parameter int RW   = RIDX,
  parameter int OW   = OPW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    policy,
  input  logic [DW-1:0] id_instr,
  input  logic [DW-1:0] rf_rs_val,
  input  logic [DW-1:0] rf_rt_val,
  input  logic          ex_regwrite,
  input  logic          ex_memread,
  input  logic [RW-1:0] ex_dest,
  input  logic [DW-1:0] ex_result,
  input  logic          mem_regwrite,
  input  logic [RW-1:0] mem_dest,
  input  logic [DW-1:0] mem_result,
  output logic          stall,
  output logic          bubble_ex,
  output logic [1:0]    fwd_rs_sel,
  output logic [1:0]    fwd_rt_sel,
  output logic [DW-1:0] opnd_rs,
  output logic [DW-1:0] opnd_rt
);
  localparam int NSTG   = 2;
  localparam int OP_LSB = DW - OW;
  localparam int RS_LSB = OP_LSB - RW;
  localparam int RT_LSB = RS_LSB - RW;

  logic [OW-1:0] opcode;
  logic [RW-1:0] src_rs, src_rt;
  logic is_regreg, is_store, rt_is_src;

  assign opcode = id_instr[OP_LSB +: OW];
  assign src_rs = id_instr[RS_LSB +: RW];
  assign src_rt = id_instr[RT_LSB +: RW];

  hzd_classify #(.OP_W(OW)) u_cls (
    .opcode(opcode), .is_regreg(is_regreg), .is_store(is_store), .rt_is_src(rt_is_src)
  );

  logic [NSTG-1:0]          stg_we;
  logic [NSTG-1:0][RW-1:0]  stg_dest;
  logic [NSTG-1:0]          m_rs, m_rt;

  assign stg_we   = {mem_regwrite, ex_regwrite};
  assign stg_dest = {mem_dest, ex_dest};

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    hzd_match #(.R_W(RW)) u_m (
      .regwrite(stg_we[s]), .dest(stg_dest[s]),
      .src_rs(src_rs), .src_rt(src_rt), .rt_en(rt_is_src),
      .m_rs(m_rs[s]), .m_rt(m_rt[s])
    );
  end

  hzd_policy #(.NSTG(NSTG)) u_pol (
    .policy(policy), .ex_memread(ex_memread),
    .m_rs(m_rs), .m_rt(m_rt),
    .stall(stall), .sel_rs(fwd_rs_sel), .sel_rt(fwd_rt_sel)
  );

  logic [1:0]          sel   [2];
  logic [DW-1:0]       rfv   [2];
  logic [DW-1:0]       outv  [2];
  assign sel[0] = fwd_rs_sel;
  assign sel[1] = fwd_rt_sel;
  assign rfv[0] = rf_rs_val;
  assign rfv[1] = rf_rt_val;

  for (genvar k = 0; k < 2; k++) begin : g_mux
    always_comb begin
      unique case (sel[k])
        SEL_EX:  outv[k] = ex_result;
        SEL_MEM: outv[k] = mem_result;
        default: outv[k] = rfv[k];
      endcase
    end
  end

  assign opnd_rs = outv[0];
  assign opnd_rt = outv[1];

  always_ff @(posedge clk) begin
    if (rst) bubble_ex <= 1'b0;
    else     bubble_ex <= stall;
  end
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    policy,
  input logic [DW-1:0] rf_rs_val,
  input logic          ex_regwrite,
  input logic [RW-1:0] ex_dest,
  input logic [DW-1:0] ex_result,
  input logic          mem_regwrite,
  input logic [RW-1:0] mem_dest,
  input logic [DW-1:0] mem_result,
  input logic          stall,
  input logic          bubble_ex,
  input logic [1:0]    fwd_rs_sel,
  input logic [1:0]    fwd_rt_sel,
  input logic [DW-1:0] opnd_rs
);
  p_off_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'd0) |-> (!stall && fwd_rs_sel == 2'd0 && fwd_rt_sel == 2'd0));

  p_zero_dest_r1: assert property (@(posedge clk) disable iff (rst)
    ((!ex_regwrite || ex_dest == '0) && (!mem_regwrite || mem_dest == '0))
      |-> (!stall && fwd_rs_sel == 2'd0 && fwd_rt_sel == 2'd0));

  p_stallonly_nofwd_r5: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'd1 || policy == 2'd3) |-> (fwd_rs_sel == 2'd0 && fwd_rt_sel == 2'd0));

  p_stall_clears_sel_r11: assert property (@(posedge clk) disable iff (rst)
    stall |-> (fwd_rs_sel == 2'd0 && fwd_rt_sel == 2'd0 && opnd_rs == rf_rs_val));

  p_ex_value_r7: assert property (@(posedge clk) disable iff (rst)
    (fwd_rs_sel == 2'd1) |-> (opnd_rs == ex_result));

  p_mem_value_r8: assert property (@(posedge clk) disable iff (rst)
    (fwd_rs_sel == 2'd2) |-> (opnd_rs == mem_result));

  p_bubble_after_r10: assert property (@(posedge clk) disable iff (rst)
    stall |=> bubble_ex);

  p_no_bubble_r10: assert property (@(posedge clk) disable iff (rst)
    !stall |=> !bubble_ex);
endmodule

bind hazard_unit_top hzd_checker #(.DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .policy(policy), .rf_rs_val(rf_rs_val),
  .ex_regwrite(ex_regwrite), .ex_dest(ex_dest), .ex_result(ex_result),
  .mem_regwrite(mem_regwrite), .mem_dest(mem_dest), .mem_result(mem_result),
  .stall(stall), .bubble_ex(bubble_ex), .fwd_rs_sel(fwd_rs_sel),
  .fwd_rt_sel(fwd_rt_sel), .opnd_rs(opnd_rs)
);

// File: tb/tb_hazard_unit_top.sv
module tb_hazard_unit_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  localparam logic [31:0] RF_RS = 32'h1111_0000;
  localparam logic [31:0] RF_RT = 32'h2222_0000;
  localparam logic [31:0] EXV   = 32'hE0E0_00E0;
  localparam logic [31:0] MEMV  = 32'hD0D0_00D0;

  // vector: req(5) pol(2) instr(32) exrw exmr exd(5) memrw memd(5) stall sel_rs(2) sel_rt(2)
  function automatic logic [56:0] mk(input int req, input int pol, input int op,
      input int rs, input int rt, input bit exrw, input bit exmr, input int exd,
      input bit mrw, input int md, input bit st, input int srs, input int srt);
    logic [31:0] ins;
    ins = {op[5:0], rs[4:0], rt[4:0], 5'd5, 5'd0, 6'd32};
    return {req[4:0], pol[1:0], ins, exrw, exmr, exd[4:0], mrw, md[4:0], st, srs[1:0], srt[1:0]};
  endfunction

  localparam logic [56:0] TBL [NV] = '{
    mk(7, 2,  0,3,4, 1,0,3, 0,0, 0,1,0),   // R7 ADD-ADD via rs
    mk(3, 2,  0,3,4, 1,0,4, 0,0, 0,0,1),   // R3 rt of reg-reg op
    mk(3, 2,  8,3,4, 1,0,4, 0,0, 0,0,0),   // R3 immediate op rt is a dest
    mk(3, 2, 43,3,4, 1,0,4, 0,0, 0,0,1),   // R3 store 43
    mk(3, 2, 46,3,4, 1,0,4, 0,0, 0,0,1),   // R3 store 46
    mk(3, 2, 17,3,4, 1,0,4, 0,0, 0,0,0),   // R3 undefined opcode
    mk(6, 2,  0,3,4, 1,1,3, 0,0, 1,0,0),   // R6 load-use stall
    mk(8, 2,  0,3,4, 0,0,0, 1,4, 0,0,2),   // R8 memory forward
    mk(9, 2,  0,3,4, 1,0,3, 1,3, 0,1,0),   // R9 execute wins
    mk(1, 2,  0,0,0, 1,0,0, 1,0, 0,0,0),   // R1 destination 0
    mk(1, 2,  0,3,4, 0,0,3, 0,3, 0,0,0),   // R1 no write flag
    mk(2, 2,  0,3,3, 1,0,3, 0,0, 0,1,1),   // R2 both operands
    mk(11,2,  0,3,4, 1,1,3, 1,4, 1,0,0),   // R11 stall overrides mem fwd
    mk(8, 2,  0,3,4, 1,1,9, 1,3, 0,2,0),   // R8 load data from mem stage
    mk(5, 1,  0,3,4, 1,0,3, 0,0, 1,0,0),   // R5 execute dep
    mk(5, 1,  0,3,4, 0,0,0, 1,4, 1,0,0),   // R5 memory dep
    mk(5, 1,  8,3,4, 1,0,4, 0,0, 0,0,0),   // R5 immediate rt ignored
    mk(1, 1,  0,0,4, 1,0,0, 0,0, 0,0,0),   // R1 r0 under stall-only
    mk(4, 0,  0,3,4, 1,1,3, 0,0, 0,0,0),   // R4 off
    mk(4, 0,  0,3,4, 0,0,0, 1,4, 0,0,0),   // R4 off memory
    mk(12,3,  0,3,4, 1,0,3, 0,0, 1,0,0)    // R12 reserved as stall-only
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] policy = '0;
  logic [31:0] id_instr = '0;
  logic ex_regwrite = 0, ex_memread = 0, mem_regwrite = 0;
  logic [4:0] ex_dest = '0, mem_dest = '0;
  logic stall, bubble_ex;
  logic [1:0] fwd_rs_sel, fwd_rt_sel;
  logic [31:0] opnd_rs, opnd_rt;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_unit_top dut (
    .clk(clk), .rst(rst), .policy(policy), .id_instr(id_instr),
    .rf_rs_val(RF_RS), .rf_rt_val(RF_RT),
    .ex_regwrite(ex_regwrite), .ex_memread(ex_memread), .ex_dest(ex_dest), .ex_result(EXV),
    .mem_regwrite(mem_regwrite), .mem_dest(mem_dest), .mem_result(MEMV),
    .stall(stall), .bubble_ex(bubble_ex), .fwd_rs_sel(fwd_rs_sel), .fwd_rt_sel(fwd_rt_sel),
    .opnd_rs(opnd_rs), .opnd_rt(opnd_rt)
  );

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] opval(input logic [1:0] s, input logic [31:0] rf);
    return (s == 2'd1) ? EXV : (s == 2'd2) ? MEMV : rf;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R10 reset state
    repeat (2) @(posedge clk);
    #1 check(10, "bubble in reset", {31'd0, bubble_ex}, 32'd0);
    // R10 reset holds bubble low even when a stall is present
    @(negedge clk);
    policy = 2'd1; id_instr = {6'd0, 5'd3, 5'd4, 16'd0};
    ex_regwrite = 1; ex_dest = 5'd3;
    @(posedge clk); #1;
    check(10, "stall during reset", {31'd0, stall}, 32'd1);
    check(10, "bubble held by reset", {31'd0, bubble_ex}, 32'd0);
    @(negedge clk); rst = 0;

    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      int req;
      logic est;
      logic [1:0] ers, ert;
      v = TBL[i];
      req = int'(v[56:52]);
      @(negedge clk);
      policy = v[51:50]; id_instr = v[49:18];
      ex_regwrite = v[17]; ex_memread = v[16]; ex_dest = v[15:11];
      mem_regwrite = v[10]; mem_dest = v[9:5];
      est = v[4]; ers = v[3:2]; ert = v[1:0];
      #1;
      check(req, $sformatf("v%0d stall", i), {31'd0, stall}, {31'd0, est});
      check(req, $sformatf("v%0d rs sel", i), {30'd0, fwd_rs_sel}, {30'd0, ers});
      check(req, $sformatf("v%0d rt sel", i), {30'd0, fwd_rt_sel}, {30'd0, ert});
      check(req, $sformatf("v%0d rs val", i), opnd_rs, opval(ers, RF_RS));
      check(req, $sformatf("v%0d rt val", i), opnd_rt, opval(ert, RF_RT));
      @(posedge clk); #1;
      check(10, $sformatf("v%0d bubble", i), {31'd0, bubble_ex}, {31'd0, est});
    end

    // R10 bubble drops after stall goes away
    @(negedge clk);
    policy = 2'd0;
    @(posedge clk); #1;
    check(10, "bubble clears", {31'd0, bubble_ex}, 32'd0);

    // R9 execute priority on the second operand as well
    @(negedge clk);
    policy = 2'd2; id_instr = {6'd0, 5'd7, 5'd4, 16'd0};
    ex_regwrite = 1; ex_memread = 0; ex_dest = 5'd4;
    mem_regwrite = 1; mem_dest = 5'd4;
    #1;
    check(9, "rt priority sel", {30'd0, fwd_rt_sel}, 32'd1);
    check(9, "rt priority val", opnd_rt, EXV);

    summary();
  end
endmodule